// File: doc/BRIEF.md
# Transmit DMA Credit and Error Monitor

This block watches a set of transmit DMA channels (eight by default) and reports how each one is configured, whether it is idle, and whether any handshake between the channel, its scheduler and its downstream FIFO has broken protocol. Each channel holds a 2-bit operating mode and a request-enable bit, a one-entry request buffer that is filled by an activate command from the scheduler and emptied when the channel retires that command, and a credit counter that tracks free space in the FIFO behind it.

Errors come from handshake mismatches, not from data faults. A command error is raised when an activate command reaches a channel whose request buffer is still occupied. A credit error is raised when the FIFO signals full while the channel still believes it has credit left. Two global strobes flag an internal-memory address error and a dword-count mismatch from the host. All error flags are sticky, and software clears them by writing ones.

Top module: `txcred_mon`

## Requirements
- R1: After a synchronous active-high reset every channel is in mode 00 with request enable 0 and an empty request buffer, every credit counter equals CREDIT_MAX, and the error word is zero.
- R2: A configuration write sets the mode and request enable of the channel selected by cfg_sel only, from the next cycle on. Mode encoding: 00 halt, 01 drain (stop at end of frame), 10 run, 11 treated as halt. ch_run[i] is 1 exactly when channel i is in mode 10 with request enable 1.
- R3: An activate command to a channel with an empty request buffer fills the buffer from the next cycle only when ch_run is 1 for that channel; otherwise it is ignored and the buffer stays empty.
- R4: A done strobe empties an occupied request buffer when the channel is in mode 10 or 01; in mode 00 or 11 it is ignored and the buffer stays occupied.
- R5: An activate command to a channel whose request buffer is occupied sets error bit 9+i (bits 16:9, one per channel) in the next cycle, whatever the mode, and leaves the buffer occupied.
- R6: A word-sent strobe lowers a channel's credit by one, holding at zero rather than wrapping; a credit-return strobe reloads CREDIT_MAX and wins over a word-sent strobe in the same cycle.
- R7: A FIFO-full indication on channel i while its credit is nonzero sets error bit i (bits 7:0) in the next cycle; with credit at zero it sets nothing.
- R8: An address-error strobe sets error bit 31 and a dword-mismatch strobe sets error bit 30 in the next cycle.
- R9: Error bits are sticky: a bit falls only when err_clr_we is 1 with a 1 in that bit position of err_clr_data; zeros in err_clr_data leave bits unchanged, and a new error event in the same cycle as its clear leaves the bit set.
- R10: Status bit 24+i is 1 when buf_empty[i] is 1 and channel i's request buffer is empty; status bit 16+i is the inverse of req_pend[i]; bits 15:0 and unused channel positions are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | SELW | Channel chosen by the configuration write |
| cfg_mode | input | 2 | Mode written (00 halt, 01 drain, 10 run, 11 halt) |
| cfg_dreq | input | 1 | Request-enable bit written |
| act_cmd | input | NCH | Activate command from the scheduler, one per channel |
| cmd_done | input | NCH | Channel has retired its buffered command |
| word_sent | input | NCH | One word pushed into the channel's FIFO |
| credit_ret | input | NCH | FIFO returned all credit |
| fifo_full | input | NCH | FIFO full indication |
| buf_empty | input | NCH | Channel data buffers empty |
| req_pend | input | NCH | Channel has an outstanding request |
| addr_err | input | 1 | Internal-memory address error strobe |
| dword_err | input | 1 | Host dword-count mismatch strobe |
| err_clr_we | input | 1 | Write-one-to-clear strobe for the error word |
| err_clr_data | input | 32 | Bits to clear in the error word |
| status_word | output | 32 | Per-channel empty (31:24) and no-pending (23:16) flags |
| err_word | output | 32 | Sticky error flags |
| ch_run | output | NCH | Channel accepts new commands |
| credit_flat | output | NCH*CW | Credit counters, channel i at bits i*CW upward |

## Verification
The bench pushes activate commands into channels in every mode, including run with requests disabled and the reserved mode, so a design that accepted commands outside full run, or that let a halted channel retire its command, drifts from the model. It drains a credit counter past zero and returns credit in the same cycle as a word, catching a counter that wraps to its maximum or lets the decrement win. It raises the FIFO-full indication once with credit left and once with none, separating a correct credit check from one that fires on every full. It clears error bits with partial masks and in the same cycle as a new event on the same bit, which exposes a clear that takes priority or a clear that acts on zero bits.

// File: rtl/txcred_pkg.sv
package txcred_pkg;

    typedef enum logic [1:0] {
        MODE_HALT  = 2'b00,
        MODE_DRAIN = 2'b01,
        MODE_RUN   = 2'b10,
        MODE_RSVD  = 2'b11
    } chan_mode_e;

    typedef struct packed {
        chan_mode_e mode;
        logic       dreq_en;
    } chan_cfg_t;

    localparam int MAX_CH        = 8;
    localparam int ERR_ADDR_BIT  = 31;
    localparam int ERR_DWORD_BIT = 30;
    localparam int ERR_CMD_LSB   = 9;
    localparam int ERR_CRED_LSB  = 0;
    localparam int STS_EMPTY_LSB = 24;
    localparam int STS_IDLE_LSB  = 16;

    // New commands are taken only in full run with requests enabled.
    function automatic logic takes_new(chan_cfg_t c);
        return (c.mode == MODE_RUN) && c.dreq_en;
    endfunction

    // A buffered command may retire in run or drain.
    function automatic logic may_retire(chan_cfg_t c);
        return (c.mode == MODE_RUN) || (c.mode == MODE_DRAIN);
    endfunction

endpackage

// File: rtl/txcred_chan.sv
module txcred_chan
    import txcred_pkg::*;
#(
    parameter int CREDIT_MAX = 6,
    parameter int CW         = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_mode,
    input  logic          cfg_dreq,
    input  logic          act,
    input  logic          done,
    input  logic          word_sent,
    input  logic          credit_ret,
    input  logic          fifo_full,
    output logic          run,
    output logic          occupied,
    output logic [CW-1:0] credit,
    output logic          cmd_err,
    output logic          cred_err
);

    localparam logic [CW-1:0] FULL_CREDIT = CW'(CREDIT_MAX);

    chan_cfg_t     cfg_q;
    logic          occ_q, occ_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        if (occ_q) begin
            occ_d = !(done && may_retire(cfg_q));
        end else begin
            occ_d = act && takes_new(cfg_q);
        end
    end

    always_comb begin
        if (credit_ret) begin
            cnt_d = FULL_CREDIT;
        end else if (word_sent && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '{mode: MODE_HALT, dreq_en: 1'b0};
            occ_q <= 1'b0;
            cnt_q <= FULL_CREDIT;
        end else begin
            if (cfg_we) begin
                cfg_q <= '{mode: chan_mode_e'(cfg_mode), dreq_en: cfg_dreq};
            end
            occ_q <= occ_d;
            cnt_q <= cnt_d;
        end
    end

    assign run      = takes_new(cfg_q);
    assign occupied = occ_q;
    assign credit   = cnt_q;
    assign cmd_err  = act && occ_q;
    assign cred_err = fifo_full && (cnt_q != '0);

endmodule

// File: rtl/txcred_errs.sv
module txcred_errs
    import txcred_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] cmd_err,
    input  logic [NCH-1:0] cred_err,
    input  logic           addr_err,
    input  logic           dword_err,
    input  logic           clr_we,
    input  logic [31:0]    clr_data,
    output logic [31:0]    err_word
);

    logic [31:0] err_q, set_v, clr_v;

    always_comb begin
        set_v = '0;
        set_v[ERR_ADDR_BIT]  = addr_err;
        set_v[ERR_DWORD_BIT] = dword_err;
        for (int i = 0; i < NCH; i++) begin
            set_v[ERR_CMD_LSB + i]  = cmd_err[i];
            set_v[ERR_CRED_LSB + i] = cred_err[i];
        end
        clr_v = clr_we ? clr_data : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= '0;
        end else begin
            err_q <= (err_q & ~clr_v) | set_v;
        end
    end

    assign err_word = err_q;

endmodule

// File: rtl/txcred_mon.sv
module txcred_mon
    import txcred_pkg::*;
#(
    parameter int NCH        = 8,
    parameter int CREDIT_MAX = 6,
    localparam int CW        = $clog2(CREDIT_MAX + 1),
    localparam int SELW      = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [SELW-1:0]   cfg_sel,
    input  logic [1:0]        cfg_mode,
    input  logic              cfg_dreq,
    input  logic [NCH-1:0]    act_cmd,
    input  logic [NCH-1:0]    cmd_done,
    input  logic [NCH-1:0]    word_sent,
    input  logic [NCH-1:0]    credit_ret,
    input  logic [NCH-1:0]    fifo_full,
    input  logic [NCH-1:0]    buf_empty,
    input  logic [NCH-1:0]    req_pend,
    input  logic              addr_err,
    input  logic              dword_err,
    input  logic              err_clr_we,
    input  logic [31:0]       err_clr_data,
    output logic [31:0]       status_word,
    output logic [31:0]       err_word,
    output logic [NCH-1:0]    ch_run,
    output logic [NCH*CW-1:0] credit_flat
);

    logic [NCH-1:0] occ_v, cmd_err_v, cred_err_v;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        txcred_chan #(
            .CREDIT_MAX (CREDIT_MAX),
            .CW         (CW)
        ) u_chan (
            .clk        (clk),
            .rst        (rst),
            .cfg_we     (cfg_we && (cfg_sel == SELW'(i))),
            .cfg_mode   (cfg_mode),
            .cfg_dreq   (cfg_dreq),
            .act        (act_cmd[i]),
            .done       (cmd_done[i]),
            .word_sent  (word_sent[i]),
            .credit_ret (credit_ret[i]),
            .fifo_full  (fifo_full[i]),
            .run        (ch_run[i]),
            .occupied   (occ_v[i]),
            .credit     (credit_flat[i*CW +: CW]),
            .cmd_err    (cmd_err_v[i]),
            .cred_err   (cred_err_v[i])
        );
    end

    txcred_errs #(
        .NCH (NCH)
    ) u_errs (
        .clk      (clk),
        .rst      (rst),
        .cmd_err  (cmd_err_v),
        .cred_err (cred_err_v),
        .addr_err (addr_err),
        .dword_err(dword_err),
        .clr_we   (err_clr_we),
        .clr_data (err_clr_data),
        .err_word (err_word)
    );

    always_comb begin
        status_word = '0;
        for (int i = 0; i < NCH; i++) begin
            status_word[STS_EMPTY_LSB + i] = buf_empty[i] && !occ_v[i];
            status_word[STS_IDLE_LSB + i]  = !req_pend[i];
        end
    end

endmodule

// File: rtl/txcred_mon_chk.sv
module txcred_mon_chk #(
    parameter int NCH        = 8,
    parameter int CREDIT_MAX = 6,
    parameter int CW         = 3,
    parameter int SELW       = 3
) (
    input logic              clk,
    input logic              rst,
    input logic [NCH-1:0]    word_sent,
    input logic [NCH-1:0]    credit_ret,
    input logic [NCH-1:0]    fifo_full,
    input logic              addr_err,
    input logic              dword_err,
    input logic              err_clr_we,
    input logic [31:0]       status_word,
    input logic [31:0]       err_word,
    input logic [NCH*CW-1:0] credit_flat
);

    // R8
    addr_flag_chk: assert property (@(posedge clk) disable iff (rst)
        addr_err |=> err_word[31]);

    // R8
    dword_flag_chk: assert property (@(posedge clk) disable iff (rst)
        dword_err |=> err_word[30]);

    // R9
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !err_clr_we |=> ((err_word & $past(err_word)) == $past(err_word)));

    // R10
    status_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
        status_word[15:0] == 16'h0000);

    for (genvar i = 0; i < NCH; i++) begin : g_c
        // R7
        cred_err_chk: assert property (@(posedge clk) disable iff (rst)
            (fifo_full[i] && (credit_flat[i*CW +: CW] != '0)) |=> err_word[i]);

        // R6
        no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
            (word_sent[i] && !credit_ret[i] && (credit_flat[i*CW +: CW] == '0))
            |=> (credit_flat[i*CW +: CW] == '0));

        // R6
        reload_chk: assert property (@(posedge clk) disable iff (rst)
            credit_ret[i] |=> (credit_flat[i*CW +: CW] == CW'(CREDIT_MAX)));
    end

endmodule

bind txcred_mon txcred_mon_chk #(
    .NCH        (NCH),
    .CREDIT_MAX (CREDIT_MAX),
    .CW         (CW),
    .SELW       (SELW)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .word_sent   (word_sent),
    .credit_ret  (credit_ret),
    .fifo_full   (fifo_full),
    .addr_err    (addr_err),
    .dword_err   (dword_err),
    .err_clr_we  (err_clr_we),
    .status_word (status_word),
    .err_word    (err_word),
    .credit_flat (credit_flat)
);

// File: tb/txcred_mon_bench.sv
`timescale 1ns/1ps
module txcred_mon_bench;

    localparam int NCH  = 8;
    localparam int CMAX = 6;
    localparam int CW   = 3;
    localparam int SELW = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_we = 1'b0;
    logic [SELW-1:0]   cfg_sel = '0;
    logic [1:0]        cfg_mode = '0;
    logic              cfg_dreq = 1'b0;
    logic [NCH-1:0]    act_cmd = '0, cmd_done = '0, word_sent = '0;
    logic [NCH-1:0]    credit_ret = '0, fifo_full = '0;
    logic [NCH-1:0]    buf_empty = '1, req_pend = '0;
    logic              addr_err = 1'b0, dword_err = 1'b0, err_clr_we = 1'b0;
    logic [31:0]       err_clr_data = '0;
    logic [31:0]       status_word, err_word;
    logic [NCH-1:0]    ch_run;
    logic [NCH*CW-1:0] credit_flat;

    txcred_mon #(.NCH(NCH), .CREDIT_MAX(CMAX)) u_txcred_mon (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_mode(cfg_mode), .cfg_dreq(cfg_dreq), .act_cmd(act_cmd),
        .cmd_done(cmd_done), .word_sent(word_sent), .credit_ret(credit_ret),
        .fifo_full(fifo_full), .buf_empty(buf_empty), .req_pend(req_pend),
        .addr_err(addr_err), .dword_err(dword_err), .err_clr_we(err_clr_we),
        .err_clr_data(err_clr_data), .status_word(status_word),
        .err_word(err_word), .ch_run(ch_run), .credit_flat(credit_flat)
    );

    always #2.5 clk = ~clk;

    int    n_checks = 0;
    int    n_fail   = 0;
    int    cycles   = 0;
    bit    started  = 0;
    bit    finished = 0;
    string phase    = "R1";

    // Behavioural reference state
    int          m_mode [NCH];
    bit          m_dreq [NCH];
    bit          m_occ  [NCH];
    int          m_cred [NCH];
    logic [31:0] m_err;

    task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        started = 1;
        if (rst) begin
            for (int i = 0; i < NCH; i++) begin
                m_mode[i] = 0; m_dreq[i] = 0; m_occ[i] = 0; m_cred[i] = CMAX;
            end
            m_err = '0;
        end else begin
            logic [31:0] setb;
            logic [31:0] clrb;
            setb = '0;
            setb[31] = addr_err;
            setb[30] = dword_err;
            for (int i = 0; i < NCH; i++) begin
                if (act_cmd[i] && m_occ[i]) setb[9 + i] = 1'b1;
                if (fifo_full[i] && m_cred[i] != 0) setb[i] = 1'b1;
                if (m_occ[i]) begin
                    if (cmd_done[i] && (m_mode[i] == 2 || m_mode[i] == 1)) m_occ[i] = 0;
                end else if (act_cmd[i] && m_mode[i] == 2 && m_dreq[i]) begin
                    m_occ[i] = 1;
                end
                if (credit_ret[i]) m_cred[i] = CMAX;
                else if (word_sent[i] && m_cred[i] > 0) m_cred[i] = m_cred[i] - 1;
                if (cfg_we && int'(cfg_sel) == i) begin
                    m_mode[i] = int'(cfg_mode);
                    m_dreq[i] = cfg_dreq;
                end
            end
            clrb = err_clr_we ? err_clr_data : '0;
            m_err = (m_err & ~clrb) | setb;
        end
    end

    always @(negedge clk) begin
        if (started && !finished) begin
            logic [31:0] es;
            logic [NCH-1:0] er;
            es = '0;
            for (int i = 0; i < NCH; i++) begin
                es[24 + i] = buf_empty[i] && !m_occ[i];
                es[16 + i] = !req_pend[i];
                er[i] = (m_mode[i] == 2) && m_dreq[i];
                chk(credit_flat[i*CW +: CW] == CW'(m_cred[i]), phase, "credit",
                    32'(credit_flat[i*CW +: CW]), 32'(m_cred[i]));
            end
            chk(err_word == m_err, phase, "err_word", err_word, m_err);
            chk(status_word == es, phase, "status_word", status_word, es);
            chk(ch_run == er, phase, "ch_run", 32'(ch_run), 32'(er));
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic quiet();
        cfg_we = 0; act_cmd = '0; cmd_done = '0; word_sent = '0; credit_ret = '0;
        fifo_full = '0; addr_err = 0; dword_err = 0; err_clr_we = 0; err_clr_data = '0;
    endtask

    task automatic cfg(int ch, logic [1:0] md, logic dq);
        cfg_we = 1; cfg_sel = SELW'(ch); cfg_mode = md; cfg_dreq = dq;
        tick();
        quiet();
    endtask

    task automatic finish_run();
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            if (cycles > 20000 && !finished) begin
                n_checks++; n_fail++;
                $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
                finish_run();
            end
        end
    end

    initial begin
        quiet();
        rst = 1;
        repeat (3) tick();
        rst = 0;
        tick();
        // R1 explicit reset-state check
        chk(err_word == 0 && ch_run == 0, "R1", "reset state", err_word, 0);
        chk(credit_flat == {NCH{CW'(CMAX)}}, "R1", "reset credit", 32'(credit_flat[CW-1:0]), CMAX);

        phase = "R2";
        cfg(2, 2'b10, 1); cfg(5, 2'b10, 0); cfg(3, 2'b11, 1); cfg(0, 2'b01, 1);
        tick();
        chk(ch_run == 8'b0000_0100, "R2", "run mask", 32'(ch_run), 32'h04);

        phase = "R3";
        act_cmd = 8'b0010_1101; tick(); quiet(); tick();
        chk(status_word[31:24] == 8'b1111_1011, "R3", "empty flags", 32'(status_word[31:24]), 32'hFB);

        phase = "R5";
        act_cmd = 8'b0000_0100; tick(); quiet(); tick();
        chk(err_word[11] == 1'b1, "R5", "cmd err ch2", err_word, 32'h800);

        phase = "R4";
        cfg(2, 2'b00, 1);
        cmd_done = 8'b0000_0100; tick(); quiet(); tick();
        chk(status_word[26] == 1'b0, "R4", "halt keeps buffer", 32'(status_word[26]), 0);
        cfg(2, 2'b01, 0);
        cmd_done = 8'b0000_0100; tick(); quiet(); tick();
        chk(status_word[26] == 1'b1, "R4", "drain frees buffer", 32'(status_word[26]), 1);

        phase = "R6";
        for (int k = 0; k < CMAX + 3; k++) begin word_sent = 8'b0001_0010; tick(); end
        quiet(); tick();
        chk(credit_flat[1*CW +: CW] == 0, "R6", "saturate", 32'(credit_flat[1*CW +: CW]), 0);
        word_sent = 8'b0000_0010; credit_ret = 8'b0000_0010; tick(); quiet(); tick();
        chk(credit_flat[1*CW +: CW] == CW'(CMAX), "R6", "reload wins", 32'(credit_flat[1*CW +: CW]), CMAX);

        phase = "R7";
        fifo_full = 8'b0001_0010; tick(); quiet(); tick();
        chk(err_word[1] == 1 && err_word[4] == 0, "R7", "credit err", err_word, 32'h2);

        phase = "R8";
        addr_err = 1; tick(); quiet(); dword_err = 1; tick(); quiet(); tick();
        chk(err_word[31:30] == 2'b11, "R8", "global flags", err_word, 32'hC0000000);

        phase = "R9";
        err_clr_we = 1; err_clr_data = 32'h4000_0002; tick(); quiet(); tick();
        chk(err_word[30] == 0 && err_word[31] == 1, "R9", "partial clear", err_word, m_err);
        err_clr_we = 1; err_clr_data = 32'h8000_0000; addr_err = 1; tick(); quiet(); tick();
        chk(err_word[31] == 1, "R9", "set beats clear", err_word, m_err);
        err_clr_we = 1; err_clr_data = 32'hFFFF_FFFF; tick(); quiet(); tick();
        chk(err_word == 0, "R9", "full clear", err_word, 0);

        phase = "R10";
        req_pend = 8'b1010_0101; buf_empty = 8'b0110_1111; tick(); tick();
        req_pend = 8'b0000_0000; buf_empty = 8'b1111_1111; tick();

        phase = "R3";
        for (int k = 0; k < 600; k++) begin
            cfg_we       = ($urandom % 6) == 0;
            cfg_sel      = SELW'($urandom);
            cfg_mode     = 2'($urandom);
            cfg_dreq     = 1'($urandom);
            act_cmd      = NCH'($urandom) & NCH'($urandom);
            cmd_done     = NCH'($urandom);
            word_sent    = NCH'($urandom);
            credit_ret   = NCH'($urandom) & NCH'($urandom) & NCH'($urandom);
            fifo_full    = NCH'($urandom) & NCH'($urandom);
            buf_empty    = NCH'($urandom);
            req_pend     = NCH'($urandom);
            addr_err     = ($urandom % 9) == 0;
            dword_err    = ($urandom % 9) == 0;
            err_clr_we   = ($urandom % 4) == 0;
            err_clr_data = $urandom;
            tick();
        end
        quiet();
        tick(); tick();
        finish_run();
    end

endmodule